// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Generator

This block drives eight pulse-width-modulated outputs from one common 256-tick period. A single 8-bit period counter counts down once per enabled tick. When it reaches zero, a new period begins: every output goes high and each channel's down-counter is reloaded from that channel's duty register. On each later tick every channel counter steps down by one. The channel whose counter lands on zero is switched off. This is done by ANDing a mask of still-running channels into the registered output state.

Software, or a neighbouring block, programs the eight duty registers through a small write port with a channel address, a data byte and a strobe. The running counters are never written directly, so a new duty value shapes the pulse only from the next period onward. An external strobe paces the whole block. While that strobe is low, nothing moves.

Top module: `pwm_bank_top`

## Requirements
- R1: While `rst` is high at a clock edge, `pwm_o` becomes 0 and every duty register becomes 0. The first enabled tick after reset starts a period.
- R2: Period starts are exactly 256 enabled ticks apart.
- R3: On a period-start tick, all eight bits of `pwm_o` go high at that clock edge.
- R4: A channel whose latched duty d is between 1 and 255 is high for exactly d enabled ticks, counting the start tick, and then goes low. A duty of 1 gives a one-tick pulse.
- R5: A channel whose latched duty is 0 stays high for the whole period.
- R6: A duty value is latched only on a period-start tick. A write in the middle of a period leaves the current pulse unchanged. A write in the same cycle as a period-start tick takes effect in the following period.
- R7: When `tick_en` is low, `pwm_o` and all counters hold their values.
- R8: A channel that has gone low stays low until the next period start.
- R9: A write with `wr_en` high stores `wr_duty` into the duty register of channel `wr_ch`, where value k selects the channel on bit k of `pwm_o`. No other channel is affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Advance strobe; one tick per cycle while high |
| wr_en | input | 1 | Duty register write strobe |
| wr_ch | input | 3 | Channel index for the write |
| wr_duty | input | 8 | Duty value to store |
| pwm_o | output | 8 | Registered PWM outputs, bit k is channel k |

## Verification
A duty write and a period-start reload can fall in the same clock edge. That edge must latch the old duty register value while storing the new one. The bench provokes this by issuing a write on the exact tick whose model phase marks a period start. It then compares every cycle of that period and the next against a behavioural model, which latches duties before applying the write. Mid-period writes are also issued while ticks run, and while `tick_en` is low, to confirm that the current pulse is untouched.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int unsigned CH_N = 8;
    localparam int unsigned CW   = 8;

    typedef enum logic {
        PH_RUN   = 1'b0,
        PH_START = 1'b1
    } phase_e;

    typedef struct packed {
        logic   tick;
        phase_e phase;
    } tick_ctl_t;

endpackage

// File: rtl/pwm_period_ctr.sv
module pwm_period_ctr
    import pwm_pkg::*;
#(
    parameter int unsigned W = CW
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick_en,
    output tick_ctl_t ctl
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= W'(1);
        end else if (tick_en) begin
            cnt_q <= cnt_q - W'(1);
        end
    end

    always_comb begin
        ctl.tick  = tick_en;
        ctl.phase = (tick_en && cnt_q == W'(1)) ? PH_START : PH_RUN;
    end

endmodule

// File: rtl/pwm_duty_bank.sv
module pwm_duty_bank #(
    parameter int unsigned NCH = 8,
    parameter int unsigned W   = 8,
    localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_ch,
    input  logic [W-1:0]          wr_duty,
    output logic [NCH-1:0][W-1:0] duty_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                duty_o[g] <= '0;
            end else if (wr_en && wr_ch == AW'(g)) begin
                duty_o[g] <= wr_duty;
            end
        end
    end

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_pkg::*;
#(
    parameter int unsigned W = CW
) (
    input  logic      clk,
    input  logic      rst,
    input  tick_ctl_t ctl,
    input  logic [W-1:0] duty,
    output logic      alive_o
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ctl.tick) begin
            if (ctl.phase == PH_START) cnt_q <= duty;
            else                       cnt_q <= cnt_q - W'(1);
        end
    end

    // Counter stays nonzero after the next decrement unless it holds 1.
    assign alive_o = (cnt_q != W'(1));

    // R4
    unit_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.tick && ctl.phase == PH_START && duty == W'(1)) |=> !alive_o);

endmodule

// File: rtl/pwm_bank_top.sv
module pwm_bank_top
    import pwm_pkg::*;
#(
    parameter int unsigned NCH = CH_N,
    parameter int unsigned W   = CW,
    localparam int unsigned AW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick_en,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_ch,
    input  logic [W-1:0]   wr_duty,
    output logic [NCH-1:0] pwm_o
);

    tick_ctl_t             ctl;
    logic [NCH-1:0][W-1:0] duty_all;
    logic [NCH-1:0]        alive;
    logic [NCH-1:0]        state_q;

    pwm_period_ctr #(.W(W)) u_period (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .ctl     (ctl)
    );

    pwm_duty_bank #(.NCH(NCH), .W(W)) u_duty (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_duty (wr_duty),
        .duty_o  (duty_all)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst     (rst),
            .ctl     (ctl),
            .duty    (duty_all[g]),
            .alive_o (alive[g])
        );

        // R8
        stay_low_chk: assert property (@(posedge clk) disable iff (rst)
            (ctl.phase != PH_START && !state_q[g]) |=> !pwm_o[g]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (ctl.tick) begin
            if (ctl.phase == PH_START) state_q <= '1;
            else                       state_q <= state_q & alive;
        end
    end

    assign pwm_o = state_q;

    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> (pwm_o == '0));

    // R3
    start_high_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.tick && ctl.phase == PH_START) |=> (&pwm_o));

    // R7
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(pwm_o));

endmodule

// File: tb/pwm_bank_top_tb.sv
module pwm_bank_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick_en;
    logic       wr_en;
    logic [2:0] wr_ch;
    logic [7:0] wr_duty;
    logic [7:0] pwm_o;

    int errors = 0;
    int checks = 0;

    int  duty_m [8];
    int  lat_m  [8];
    int  t_m;
    bit  started;
    int  tick_idx;
    int  last_rise;
    logic prev_b1;

    always #10 clk = ~clk;

    pwm_bank_top u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
        .wr_ch(wr_ch), .wr_duty(wr_duty), .pwm_o(pwm_o)
    );

    function automatic logic [7:0] expect_out();
        logic [7:0] e = '0;
        for (int i = 0; i < 8; i++)
            e[i] = started && (lat_m[i] == 0 || t_m < lat_m[i]);
        return e;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: pwm_o=%h expected %h (t=%0d)", tag, act, exp, t_m);
        end
    endtask

    task automatic step(input logic te, input logic we, input int ch, input int d,
                        input string tag);
        @(negedge clk);
        tick_en = te; wr_en = we; wr_ch = 3'(ch); wr_duty = 8'(d);
        @(posedge clk);
        if (te) begin
            tick_idx++;
            if (!started || t_m == 255) begin
                started = 1;
                t_m = 0;
                for (int i = 0; i < 8; i++) lat_m[i] = duty_m[i];
            end else begin
                t_m++;
            end
        end
        if (we) duty_m[ch] = d;
        #5;
        check(tag, pwm_o, expect_out());
        if (pwm_o[1] && !prev_b1) begin
            if (last_rise >= 0) begin
                checks++;
                if (tick_idx - last_rise != 256) begin
                    errors++;
                    $display("FAIL R2: rise spacing=%0d expected 256", tick_idx - last_rise);
                end
            end
            last_rise = tick_idx;
        end
        prev_b1 = pwm_o[1];
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int dv [8] = '{0, 1, 2, 5, 128, 255, 3, 64};
        rst = 1; tick_en = 0; wr_en = 0; wr_ch = 0; wr_duty = 0;
        for (int i = 0; i < 8; i++) begin duty_m[i] = 0; lat_m[i] = 0; end
        t_m = 0; started = 0; tick_idx = 0; last_rise = -1; prev_b1 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", pwm_o, 8'h00);
        rst = 0;

        // R9: program each channel, outputs stay low before the first tick (R1)
        for (int i = 0; i < 8; i++) step(0, 1, i, dv[i], "R9");
        step(0, 0, 0, 0, "R1");

        // R3: first enabled tick starts a period, all outputs high
        step(1, 0, 0, 0, "R3");
        check("R3", pwm_o, 8'hFF);

        // R4/R8: run through most of the first period
        for (int k = 0; k < 150; k++) step(1, 0, 0, 0, "R4");
        checks++;
        if (pwm_o[0] !== 1'b1) begin
            errors++;
            $display("FAIL R5: bit0=%b expected 1", pwm_o[0]);
        end

        // R6: mid-period write must not disturb current pulse
        step(1, 1, 4, 20, "R6");
        step(1, 1, 1, 7, "R6");
        while (t_m != 254) step(1, 0, 0, 0, "R6");
        step(1, 0, 0, 0, "R6");
        // the next tick is a period start; write in the same cycle
        step(1, 1, 2, 9, "R6");
        for (int k = 0; k < 300; k++) step(1, 0, 0, 0, "R6");

        // R7: sparse ticks with writes while idle
        for (int k = 0; k < 400; k++) begin
            if (k % 3 == 0) step(1, 0, 0, 0, "R7");
            else step(0, (k % 11 == 1), k % 8, (k * 37) % 256, "R7");
        end

        // R5/R8/R2: full-rate ticks over two more periods
        step(1, 1, 6, 0, "R5");
        for (int k = 0; k < 600; k++) step(1, 0, 0, 0, "R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule